// File: doc/BRIEF.md
# System Control Register Block

This block sits on a simple 32-bit peripheral register bus with a setup phase and an access phase. It decodes a 4 KiB byte window. The lower half of the window is backed by a flat array of 32-bit words, and each word is selected by its byte offset divided by four. A few of these words start with board-specific values after reset. Three status words always read back with two fixed high bits set, and the stored contents stay as they are.

The upper half of the window has no storage. Writes there are dropped, and reads there return zero. The one exception is a power-control word at byte offset 0xF00. A write to it sends a one-cycle request to the platform: a system reset or a shutdown, chosen by the data value. Any access to the upper half other than a power-control write sets a sticky debug flag. The platform's reset controller and power sequencer act on the request pulses.

Every access finishes without wait states. Read data appears in the access phase, one cycle after the setup phase. Byte strobes and the two low address bits are not used.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word 0x41 (byte 0x104) reads 0x00000002, and bytes 0x100, 0x108 and 0x10C read 0x35F20121, 0x35F30121 and 0x35F40121 (stored presets 0x05F20121, 0x05F30121 and 0x05F40121, with the fixed bits of R4 added).
- R2: After reset, every other storage word reads zero, and rstReq, offReq and rangeErr are low.
- R3: A write to a byte offset below 0x800 stores the full 32-bit data. A later read of the same offset returns that data, in the access phase that follows the setup phase.
- R4: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. Other offsets, such as 0x104, return the stored word unchanged.
- R5: A write of 1 or 2 to byte offset 0xF00 sets rstReq high for exactly one cycle, the cycle after the access phase. offReq stays low.
- R6: A write of 3 to byte offset 0xF00 sets offReq high for exactly one cycle, the cycle after the access phase. Any other data value at 0xF00 raises neither output.
- R7: A write to 0xF00 stores nothing. In particular, word 0x1C0 (byte 0x700) is not touched.
- R8: A write at byte offset 0x800 or above is dropped and does not alias into word 0. A read at byte offset 0x800 or above returns zero.
- R9: rangeErr goes high after any access at byte offset 0x800 or above that is not a write to 0xF00. It then stays high until reset. Writes to 0xF00 leave it low.
- R10: Address bits [1:0] are ignored. A write to byte 0x013 lands in the same word as byte 0x010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Block select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| rstReq | output | 1 | One-cycle system reset request |
| offReq | output | 1 | One-cycle shutdown request |
| rangeErr | output | 1 | Sticky out-of-range access flag |

## Verification
The power-control word is exercised with data values 0, 1, 2, 3 and 5. This separates the reset request from the shutdown request from no action at all, and the pulse is sampled twice to confirm it lasts one cycle. The storage is read at preset words, forced words and unforced words, which shows whether the fixed bits are added only at the three chosen offsets. Writes to 0x800 and to 0xF00 are followed by reads of word 0 and word 0x1C0, which would expose any aliasing from dropping the top index bit. A misaligned write followed by an aligned read shows that the low address bits are ignored.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic storeEn;  // access-phase write to a backed word
    logic loadEn;   // setup-phase read, capture read data
    logic zeroRd;   // address lies above the backed range
  } dpStrobe_t;

  function automatic logic [31:0] presetWord(int unsigned idx);
    case (idx)
      32'h40:  return 32'h05F2_0121;
      32'h41:  return 32'h0000_0002;
      32'h42:  return 32'h05F3_0121;
      32'h43:  return 32'h05F4_0121;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic forcedWord(int unsigned idx);
    return (idx == 32'h40) || (idx == 32'h42) || (idx == 32'h43);
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_WORDS = 512,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-3:0] wordAddr,
  input  logic [31:0]       pwdata,
  output dpStrobe_t         strb,
  output logic              rstReq,
  output logic              offReq,
  output logic              rangeErr
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_WORDS);
  localparam logic [IDX_W-1:0] CTRL_WORD = CTRL_OFFSET[ADDR_W-1:2];

  logic accessPh, setupPh, inRange, ctrlHit, rstCode, offCode;

  always_comb begin
    accessPh = psel & penable;
    setupPh  = psel & ~penable;
    inRange  = {1'b0, wordAddr} < LIMIT;
    ctrlHit  = accessPh & pwrite & (wordAddr == CTRL_WORD);
    rstCode  = (pwdata == 32'd1) || (pwdata == 32'd2);
    offCode  = (pwdata == 32'd3) && !rstCode;
    strb.storeEn = accessPh & pwrite & inRange;
    strb.loadEn  = setupPh & ~pwrite;
    strb.zeroRd  = ~inRange;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq   <= 1'b0;
      offReq   <= 1'b0;
      rangeErr <= 1'b0;
    end else begin
      rstReq   <= ctrlHit & rstCode;
      offReq   <= ctrlHit & offCode;
      rangeErr <= rangeErr | (accessPh & ~inRange & ~ctrlHit);
    end
  end

  // R5
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(psel && penable && pwrite));
  // R6
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    offReq |-> !rstReq);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |=> rangeErr);
  // R3
  store_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeEn |-> !strb.zeroRd);

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int NUM_WORDS = 512,
  parameter logic [31:0] FORCE_MASK = 32'h3000_0000,
  localparam int MEM_IDX_W = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [MEM_IDX_W-1:0] idx,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata
);
  logic [31:0] mem [NUM_WORDS];
  logic [31:0] rdWord;
  logic        forceNow;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mem[g] <= presetWord(g);
      else if (strb.storeEn && idx == MEM_IDX_W'(g))
        mem[g] <= pwdata;
    end
  end

  always_comb begin
    rdWord   = mem[idx];
    forceNow = forcedWord(int'(idx));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      prdata <= '0;
    else if (strb.loadEn)
      prdata <= strb.zeroRd ? '0 : (rdWord | (forceNow ? FORCE_MASK : '0));
  end

  // R3
  store_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeEn |=> mem[$past(idx)] == $past(pwdata));
  // R4
  force_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && !strb.zeroRd && forceNow) |=> (prdata & FORCE_MASK) == FORCE_MASK);
  // R8
  range_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && strb.zeroRd) |=> prdata == '0);

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_WORDS = 512,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hF00,
  parameter logic [31:0] FORCE_MASK = 32'h3000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              rstReq,
  output logic              offReq,
  output logic              rangeErr
);
  localparam int MEM_IDX_W = $clog2(NUM_WORDS);

  dpStrobe_t strb;
  logic [1:0] unusedAddrLsb;
  assign unusedAddrLsb = paddr[1:0];

  sysctl_ctrl #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .CTRL_OFFSET(CTRL_OFFSET)) uCtrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .wordAddr(paddr[ADDR_W-1:2]), .pwdata(pwdata), .strb(strb),
    .rstReq(rstReq), .offReq(offReq), .rangeErr(rangeErr)
  );

  sysctl_dp #(.NUM_WORDS(NUM_WORDS), .FORCE_MASK(FORCE_MASK)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(paddr[MEM_IDX_W+1:2]),
    .pwdata(pwdata), .prdata(prdata)
  );

endmodule

// File: tb/sysctl_regs_test.sv
`timescale 1ns/1ps
module sysctl_regs_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic rstReq, offReq, rangeErr;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysctl_regs uut (.clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rstReq(rstReq), .offReq(offReq),
    .rangeErr(rangeErr));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // write; r1/o1 sampled the cycle after the access phase, r2/o2 one cycle later
  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d,
                          output logic r1, o1, r2, o2);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); r1 = rstReq; o1 = offReq; psel = 0; penable = 0; pwrite = 0;
    @(negedge clk); r2 = rstReq; o2 = offReq;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic r1, o1, r2, o2;
    apbWrite(a, d, r1, o1, r2, o2);
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apbRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic testReset();
    check("R2 rstReq idle", {31'b0, rstReq}, 0);
    check("R2 offReq idle", {31'b0, offReq}, 0);
    check("R2 rangeErr idle", {31'b0, rangeErr}, 0);
    rdChk("R1 byte 0x100", 12'h100, 32'h35F2_0121);
    rdChk("R1 byte 0x104", 12'h104, 32'h0000_0002);
    rdChk("R1 byte 0x108", 12'h108, 32'h35F3_0121);
    rdChk("R1 byte 0x10C", 12'h10C, 32'h35F4_0121);
    rdChk("R2 word 0", 12'h000, 0);
    rdChk("R2 word 0x1FF", 12'h7FC, 0);
  endtask

  task automatic testCtrl();
    logic r1, o1, r2, o2;
    for (int v = 1; v <= 2; v++) begin
      apbWrite(12'hF00, v, r1, o1, r2, o2);
      check("R5 rstReq pulse", {31'b0, r1}, 1);
      check("R5 rstReq one cycle", {31'b0, r2}, 0);
      check("R5 no offReq", {31'b0, o1}, 0);
    end
    apbWrite(12'hF00, 3, r1, o1, r2, o2);
    check("R6 offReq pulse", {31'b0, o1}, 1);
    check("R6 offReq one cycle", {31'b0, o2}, 0);
    check("R6 no rstReq", {31'b0, r1}, 0);
    apbWrite(12'hF00, 0, r1, o1, r2, o2);
    check("R6 data 0 idle", {30'b0, r1, o1}, 0);
    apbWrite(12'hF00, 5, r1, o1, r2, o2);
    check("R6 data 5 idle", {30'b0, r1, o1}, 0);
    check("R9 ctrl write no flag", {31'b0, rangeErr}, 0);
    rdChk("R7 word 0x1C0 untouched", 12'h700, 0);
  endtask

  task automatic testStore();
    wr(12'h004, 32'hA5A5_5A5A);
    rdChk("R3 word 1", 12'h004, 32'hA5A5_5A5A);
    wr(12'h7FC, 32'hDEAD_BEEF);
    rdChk("R3 last word", 12'h7FC, 32'hDEAD_BEEF);
    wr(12'h100, 32'h0000_00FF);
    rdChk("R4 forced 0x100", 12'h100, 32'h3000_00FF);
    wr(12'h104, 32'h0000_0000);
    rdChk("R4 unforced 0x104", 12'h104, 0);
    wr(12'h013, 32'h0000_0011);
    rdChk("R10 misaligned", 12'h010, 32'h0000_0011);
  endtask

  task automatic testRange();
    check("R9 flag clear before", {31'b0, rangeErr}, 0);
    wr(12'h800, 32'hFFFF_FFFF);
    check("R9 flag set by write", {31'b0, rangeErr}, 1);
    rdChk("R8 no alias to word 0", 12'h000, 0);
    rdChk("R8 upper read zero", 12'h800, 0);
    rdChk("R8 ctrl read zero", 12'hF00, 0);
    check("R9 flag sticky", {31'b0, rangeErr}, 1);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testCtrl();
    testStore();
    testRange();
    done = 1;
    finishRun();
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end
endmodule